// File: doc/BRIEF.md
# UART Channel Register Controller

This block holds the programmable state of one UART channel: the mode bytes, the status flags, the command decoder, a one-byte transmit holding register, a four-byte receive queue and the interrupt status and mask. The serial bit engine sits outside. Received bytes and line-break events come in on single-cycle strobes. Bytes leave on a single-cycle transmit strobe whenever the transmitter is enabled. A processor reaches the block through a simple byte-wide bus, where a select with no write is a read. The read data is combinational and reflects the state before the clock edge that completes the access.

The command byte packs three independent sub-commands. They are applied in a fixed order: the miscellaneous field first, then the transmitter field, then the receiver field. A later field can therefore undo an earlier one in the same write. The receive interrupt can be tied to either "queue not empty" or "queue full", chosen by a bit of the first mode byte. The interrupt line is the OR of the interrupt status bits that are left unmasked.

Top module: `uart_regctl`

## Requirements
- R1: After reset the status byte (offset 0x4) reads 0x08, the interrupt status byte (offset 0x14) reads 0x00, both mode bytes read 0, `irq`, `rx_ready` and `tx_valid` are low, and both receiver and transmitter are disabled.
- R2: Offset 0x0 reaches mode byte 1 until the first write there. Every write to it then moves the pointer to mode byte 2. The miscellaneous command 1 (command bits 6:4 = 001) returns the pointer to mode byte 1.
- R3: Accepted bytes are read back in arrival order by reading offset 0xC, and each read removes one byte. Status bit 0 is set while the queue holds a byte. Status bit 1 is set while it holds 4 bytes. Reading an empty queue returns 0 and changes nothing.
- R4: `rx_ready` is high only when the receiver is enabled and the queue is not full. A byte strobed while `rx_ready` is low is dropped.
- R5: A break strobe is taken whether or not the receiver is enabled. It sets interrupt status bit 2 and enqueues a 0x00 byte. On a full queue, the 0x00 replaces the newest byte. The miscellaneous command 5 clears bit 2.
- R6: Writing offset 0xC with the transmitter enabled gives `tx_valid` high for one cycle with the byte, and status bit 3 (empty) stays set. With the transmitter disabled, the byte is held and status bit 3 clears. A later transmitter-enable command (bits 3:2 = 01) sends the held byte and sets bit 3 again.
- R7: The miscellaneous command 2 disables the receiver and empties the queue. The miscellaneous command 3 disables the transmitter, discards a held byte and sets status bit 3.
- R8: Status bit 2 and interrupt status bit 0 follow the transmitter enable. Interrupt status bit 1 follows status bit 1 when mode byte 1 bit 6 is set, and follows status bit 0 otherwise.
- R9: `irq` is high exactly when the interrupt status byte ANDed with the mask byte (written at offset 0x14) is nonzero.
- R10: Receiver command bits 1:0 = 01 enable the receiver and 10 disable it. Transmitter command bits 3:2 = 10 disable the transmitter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Line-break event strobe |
| rx_ready | output | 1 | Receiver can take a byte |
| tx_valid | output | 1 | Transmit strobe |
| tx_data | output | 8 | Byte to transmit |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that the queue count never exceeds its depth. They also check that a rejected byte never grows the queue, that a break on a full queue leaves it full, that a transmit strobe only appears while the transmitter is enabled, and that the interrupt line never rises with an all-zero mask. Only the bench scenarios can show the byte order out of the queue, which entry a break overwrites, the mode pointer sequence, the held-byte release on enable, and how the packed command fields interact.

// File: rtl/uart_regctl.sv
module uart_regctl #(
  parameter int DEPTH = 4,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_break,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [AW-1:0] A_MODE = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(4);
  localparam logic [AW-1:0] A_CMD  = AW'(8);
  localparam logic [AW-1:0] A_DATA = AW'(12);
  localparam logic [AW-1:0] A_INT  = AW'(20);

  logic [7:0]    mr1, mr2, imr, tb;
  logic          mr_sel, tx_en, rx_en, tx_emp, dbrk;
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] cnt;

  wire wr_en  = bus_sel & bus_wr;
  wire rd_en  = bus_sel & ~bus_wr;
  wire wr_cmd = wr_en && bus_addr == A_CMD;
  wire wr_dat = wr_en && bus_addr == A_DATA;
  wire [2:0] mcmd = bus_wdata[6:4];
  wire [1:0] tcmd = bus_wdata[3:2];
  wire [1:0] rcmd = bus_wdata[1:0];

  wire full   = cnt == CW'(DEPTH);
  wire rxrdy  = cnt != '0;
  wire pop    = rd_en && bus_addr == A_DATA && rxrdy;
  wire rst_rx = wr_cmd && mcmd == 3'd2;
  wire [CW-1:0] cnt_p = cnt - CW'(pop);
  wire brk_full = cnt_p == CW'(DEPTH);
  wire push_dat = rx_valid && rx_ready && !rx_break;
  wire do_push  = (rx_break || push_dat) && !rst_rx;
  wire [PW-1:0] wr_idx = rd_ptr + PW'(pop) + (brk_full ? PW'(DEPTH - 1) : cnt_p[PW-1:0]);

  assign rx_ready = rx_en && !full;

  wire rxint = mr1[6] ? full : rxrdy;
  wire [7:0] isr  = {5'b0, dbrk, rxint, tx_en};
  wire [7:0] stat = {4'b0, tx_emp, tx_en, full, rxrdy};
  assign irq = |(isr & imr);

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = mr_sel ? mr2 : mr1;
      A_STAT:  bus_rdata = stat;
      A_DATA:  bus_rdata = rxrdy ? mem[rd_ptr] : 8'h00;
      A_INT:   bus_rdata = isr;
      default: bus_rdata = 8'h00;
    endcase
  end

  logic tx_en_n, emp_n, rx_en_n, send;
  logic [7:0] sd;
  always_comb begin
    tx_en_n = tx_en;
    emp_n   = tx_emp;
    rx_en_n = rx_en;
    send    = 1'b0;
    sd      = tb;
    if (wr_cmd) begin
      if (mcmd == 3'd2) rx_en_n = 1'b0;
      if (mcmd == 3'd3) begin
        tx_en_n = 1'b0;
        emp_n   = 1'b1;
      end
      if (tcmd == 2'd1) tx_en_n = 1'b1;
      if (tcmd == 2'd2) tx_en_n = 1'b0;
      if (tcmd == 2'd1 && !emp_n) begin
        send  = 1'b1;
        emp_n = 1'b1;
      end
      if (rcmd == 2'd1) rx_en_n = 1'b1;
      if (rcmd == 2'd2) rx_en_n = 1'b0;
    end
    if (wr_dat) begin
      if (tx_en) begin
        send = 1'b1;
        sd   = bus_wdata;
      end else begin
        emp_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr1 <= '0; mr2 <= '0; imr <= '0; tb <= '0;
      mr_sel <= 1'b0; tx_en <= 1'b0; rx_en <= 1'b0; tx_emp <= 1'b1; dbrk <= 1'b0;
      rd_ptr <= '0; cnt <= '0; tx_valid <= 1'b0; tx_data <= '0;
    end else begin
      tx_en    <= tx_en_n;
      rx_en    <= rx_en_n;
      tx_emp   <= emp_n;
      tx_valid <= send;
      if (send) tx_data <= sd;
      if (wr_dat) tb <= bus_wdata;
      if (wr_en && bus_addr == A_INT) imr <= bus_wdata;
      if (wr_en && bus_addr == A_MODE) begin
        if (mr_sel) mr2 <= bus_wdata;
        else        mr1 <= bus_wdata;
        mr_sel <= 1'b1;
      end
      if (wr_cmd && mcmd == 3'd1) mr_sel <= 1'b0;
      dbrk <= (dbrk && !(wr_cmd && mcmd == 3'd5)) || rx_break;
      if (rst_rx) begin
        cnt    <= '0;
        rd_ptr <= '0;
      end else begin
        rd_ptr <= rd_ptr + PW'(pop);
        cnt    <= cnt_p + CW'(do_push && !(rx_break && brk_full));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_idx] <= rx_break ? 8'h00 : rx_data;
  end
endmodule

// File: rtl/uart_regctl_chk.sv
module uart_regctl_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     irq,
  input logic [7:0]               imr,
  input logic                     tx_valid,
  input logic                     tx_en,
  input logic                     rx_valid,
  input logic                     rx_ready,
  input logic                     rx_break,
  input logic [$clog2(DEPTH):0]   cnt,
  input logic                     pop,
  input logic                     rst_rx
);
  localparam int CW = $clog2(DEPTH) + 1;

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH));

  // R4
  rx_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !rx_break) |=> cnt <= $past(cnt));

  // R5
  brk_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_break && cnt == CW'(DEPTH) && !pop && !rst_rx) |=> cnt == CW'(DEPTH));

  // R6
  tx_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_valid |-> tx_en);

  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> imr != 8'h00);
endmodule

bind uart_regctl uart_regctl_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (.*);

// File: tb/sim_uart_regctl.sv
module sim_uart_regctl;
  localparam int CLK = 10;
  localparam logic [1:0] OW = 2'd0, OR = 2'd1, OP = 2'd2;
  localparam int NV = 28;
  // {op, addr, data, expected}
  localparam logic [25:0] VEC [NV] = '{
    {OW, 8'h08, 8'h01, 8'h00},  // R10 rx enable
    {OR, 8'h04, 8'h00, 8'h08},  // R1
    {OP, 8'h00, 8'hA1, 8'h00},
    {OR, 8'h04, 8'h00, 8'h09},  // R3 ready
    {OP, 8'h00, 8'hA2, 8'h00},
    {OP, 8'h00, 8'hA3, 8'h00},
    {OP, 8'h00, 8'hA4, 8'h00},
    {OR, 8'h04, 8'h00, 8'h0B},  // R3 full
    {OR, 8'h14, 8'h00, 8'h02},  // R8 rx int from ready
    {OP, 8'h00, 8'hA5, 8'h00},  // R4 dropped
    {OR, 8'h0C, 8'h00, 8'hA1},
    {OR, 8'h04, 8'h00, 8'h09},
    {OR, 8'h0C, 8'h00, 8'hA2},
    {OR, 8'h0C, 8'h00, 8'hA3},
    {OR, 8'h0C, 8'h00, 8'hA4},  // R4 A5 never stored
    {OR, 8'h04, 8'h00, 8'h08},
    {OR, 8'h0C, 8'h00, 8'h00},  // R3 empty read
    {OR, 8'h04, 8'h00, 8'h08},
    {OW, 8'h00, 8'h40, 8'h00},  // R2 mode 1
    {OW, 8'h00, 8'h13, 8'h00},  // R2 mode 2
    {OR, 8'h00, 8'h00, 8'h13},
    {OW, 8'h00, 8'h15, 8'h00},
    {OR, 8'h00, 8'h00, 8'h15},
    {OW, 8'h08, 8'h10, 8'h00},  // R2 pointer reset
    {OR, 8'h00, 8'h00, 8'h40},
    {OP, 8'h00, 8'hB7, 8'h00},
    {OR, 8'h14, 8'h00, 8'h00},  // R8 rx int from full
    {OR, 8'h0C, 8'h00, 8'hB7}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, rx_data = '0;
  logic rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0] bus_rdata, tx_data;
  logic rx_ready, tx_valid, irq;
  int total = 0, fails = 0;

  always #(CLK / 2) clk = ~clk;

  uart_regctl u0 (.*);

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a[4:0]; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a[4:0];
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic rdchk(string req, logic [7:0] a, logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic push(logic [7:0] d, logic brk);
    @(negedge clk); rx_valid = !brk; rx_break = brk; rx_data = d;
    @(negedge clk); rx_valid = 0; rx_break = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(CLK * 50000);
    total++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 rx_ready", {7'b0, rx_ready}, 8'h00);
    chk("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
    rdchk("R1 status", 8'h04, 8'h08);
    rdchk("R1 isr", 8'h14, 8'h00);
    rdchk("R1 mode", 8'h00, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      case (v[25:24])
        OW: wr(v[23:16], v[15:8]);
        OR: rdchk("R2/R3/R4/R8 vector", v[23:16], v[7:0]);
        default: push(v[15:8], 1'b0);
      endcase
    end

    // R8 / R9: rx interrupt source back to ready, then mask
    wr(8'h08, 8'h10);
    wr(8'h00, 8'h00);
    push(8'hC3, 1'b0);
    rdchk("R8 isr ready source", 8'h14, 8'h02);
    wr(8'h14, 8'h02);
    chk("R9 irq unmasked", {7'b0, irq}, 8'h01);
    wr(8'h14, 8'h01);
    chk("R9 irq masked", {7'b0, irq}, 8'h00);
    rdchk("R3 pop", 8'h0C, 8'hC3);

    // R6 transmit path
    wr(8'h08, 8'h04);
    rdchk("R8 tx ready", 8'h04, 8'h0C);
    chk("R9 irq tx", {7'b0, irq}, 8'h01);
    wr(8'h14, 8'h00);
    wr(8'h0C, 8'h5A);
    chk("R6 strobe", {7'b0, tx_valid}, 8'h01);
    chk("R6 data", tx_data, 8'h5A);
    @(negedge clk);
    chk("R6 one cycle", {7'b0, tx_valid}, 8'h00);
    rdchk("R6 empty kept", 8'h04, 8'h0C);
    wr(8'h08, 8'h08);
    rdchk("R10 tx disable", 8'h04, 8'h08);
    wr(8'h0C, 8'h77);
    chk("R6 no strobe disabled", {7'b0, tx_valid}, 8'h00);
    rdchk("R6 empty cleared", 8'h04, 8'h00);
    wr(8'h08, 8'h04);
    chk("R6 held byte sent", {7'b0, tx_valid}, 8'h01);
    chk("R6 held data", tx_data, 8'h77);
    rdchk("R6 empty again", 8'h04, 8'h0C);
    // R7 transmitter reset
    wr(8'h08, 8'h08);
    wr(8'h0C, 8'h33);
    wr(8'h08, 8'h30);
    rdchk("R7 tx reset", 8'h04, 8'h08);
    wr(8'h08, 8'h04);
    chk("R7 held byte discarded", {7'b0, tx_valid}, 8'h00);

    // R5 break on full queue
    push(8'hB1, 1'b0); push(8'hB2, 1'b0); push(8'hB3, 1'b0); push(8'hB4, 1'b0);
    push(8'hEE, 1'b1);
    rdchk("R5 isr", 8'h14, 8'h07);
    rdchk("R5 full kept", 8'h04, 8'h0F);
    rdchk("R5 q0", 8'h0C, 8'hB1);
    rdchk("R5 q1", 8'h0C, 8'hB2);
    rdchk("R5 q2", 8'h0C, 8'hB3);
    rdchk("R5 newest replaced", 8'h0C, 8'h00);
    rdchk("R5 drained", 8'h04, 8'h0C);
    wr(8'h08, 8'h50);
    rdchk("R5 delta cleared", 8'h14, 8'h01);

    // R7 receiver reset
    push(8'hC1, 1'b0);
    wr(8'h08, 8'h20);
    chk("R7 rx disabled", {7'b0, rx_ready}, 8'h00);
    push(8'hC2, 1'b0);
    rdchk("R7 queue emptied", 8'h04, 8'h0C);
    rdchk("R7 empty read", 8'h0C, 8'h00);
    // R5 break while receiver disabled
    push(8'h00, 1'b1);
    rdchk("R5 break when disabled", 8'h04, 8'h0D);
    rdchk("R5 zero byte", 8'h0C, 8'h00);

    // R10 receiver enable / disable
    wr(8'h08, 8'h01);
    chk("R10 rx enable", {7'b0, rx_ready}, 8'h01);
    wr(8'h08, 8'h02);
    chk("R10 rx disable", {7'b0, rx_ready}, 8'h00);
    // R10 later field wins: reset receiver then enable in one write
    wr(8'h08, 8'h21);
    chk("R10 field order", {7'b0, rx_ready}, 8'h01);

    finish_run();
  end
endmodule